// File: doc/BRIEF.md
# Time-Shared Single-Port Character Store

This block puts one single-port character memory between two users: a processor and a display fetch engine. Each one behaves as if it owned the memory. Every clock cycle is a fixed slot. The cycle right after reset leaves is a display slot, and after that display and processor slots alternate. Because the processor never takes a display slot, the display gets a read in every other cycle, whatever the processor is doing. Because a processor request waits at most one cycle for its slot, the processor also runs without restriction and sees a constant answer time.

The memory covers a full screen: 15 rows of 33 byte-wide cells. Cell 0 of each row holds the row's initial attribute and cells 1 to 32 hold characters. Row r, cell c is stored at location r*33+c. The processor first loads a row register and a column register, then issues data reads or writes at that position. The display engine drives the row and column it needs, taken from the beam's vertical and horizontal character position, during a display slot. The byte it reads is held in an output register until the next display slot replaces it. Font lookup and pixel generation happen downstream of this block.

Top module: `dispram_slot_arbiter`

## Requirements
- R1: After reset is released, `disp_slot_o` is 1 in the first cycle and then toggles every cycle. Display reads happen only in cycles where it is 1. Processor memory accesses happen only in cycles where it is 0.
- R2: A row and column driven on the display inputs during a display slot produce that cell's byte on `disp_data_o` in the next cycle. The byte then stays unchanged for two cycles, until the following display slot's result replaces it.
- R3: The processor selector `cpu_sel_i` has these encodings. 0 loads the row register from `cpu_wdata_i[3:0]`. 1 loads the column register from `cpu_wdata_i[5:0]`. 2 is a memory access at the stored row and column, a write when `cpu_we_i` is 1 and a read otherwise. 3 does nothing.
- R4: For every memory access presented in cycle t, `cpu_ack_o` is high in cycle t+2 only, whether cycle t is a display slot or a processor slot. For a read, `cpu_rdata_o` carries the cell's byte in that same cycle. Memory accesses are issued at least two cycles apart.
- R5: Processor traffic never changes what the display reads. While the display keeps one address, `disp_data_o` keeps that cell's value during processor writes to other cells.
- R6: Each of the 15×33 row and column pairs has its own byte. Boundary neighbours such as (0,32) and (1,0) keep their contents separate.
- R7: A row of 15 or more, or a column of 33 or more, is out of range. A processor write there changes no cell. In particular, a write to (0,33) leaves (1,0) unchanged. Reads there return 0 on both the display side and the processor side.
- R8: A processor write in a processor slot, followed by a display read of the same cell in the next slot, returns the newly written byte.
- R9: While reset is held, `disp_data_o`, `cpu_rdata_o` and `cpu_ack_o` are 0, and the row and column registers are 0. A data write issued before any register load therefore goes to (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all slots are counted on it |
| rst_ni | input | 1 | Active-low synchronous reset |
| disp_slot_o | output | 1 | High in display slots |
| disp_row_i | input | 4 | Display character row |
| disp_col_i | input | 6 | Display character column |
| disp_data_o | output | 8 | Held display read result |
| cpu_valid_i | input | 1 | Processor operation present this cycle |
| cpu_sel_i | input | 2 | Operation select (row load, column load, memory access, none) |
| cpu_we_i | input | 1 | Memory access is a write |
| cpu_wdata_i | input | 8 | Register load value or write byte |
| cpu_ack_o | output | 1 | Memory access completion pulse |
| cpu_rdata_o | output | 8 | Processor read byte |

## Verification
A display result is due one cycle after its display slot and must still be there one cycle later. The bench drives the display address at the falling edge inside a display slot, then checks the byte at the next two falling edges. A processor access is due two cycles after its request cycle. The bench checks that `cpu_ack_o` is low at the first falling edge after the request and high, with the read byte, at the second. It repeats this both for requests placed in display slots and for requests placed in processor slots, which tests the one-cycle wait. The write-then-display-read case is sampled two cycles after the write cycle, when the write and the following display read have both completed.

// File: rtl/dispram_pkg.sv
package dispram_pkg;

    typedef enum logic [1:0] {
        SEL_ROW  = 2'd0,
        SEL_COL  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } sel_e;

    localparam int unsigned PORT_DISP = 0;
    localparam int unsigned PORT_CPU  = 1;
    localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/dispram_addr_map.sv
module dispram_addr_map #(
    parameter int unsigned ROWS = 15,
    parameter int unsigned COLS = 33,
    parameter int unsigned RW   = 4,
    parameter int unsigned CW   = 6,
    parameter int unsigned AW   = 9
) (
    input  logic [RW-1:0] row_i,
    input  logic [CW-1:0] col_i,
    output logic [AW-1:0] lin_o,
    output logic          in_range_o
);
    localparam int unsigned WW    = RW + CW + 1;
    localparam int unsigned DEPTH = ROWS * COLS;

    logic [WW-1:0] wide;

    always_comb begin
        wide       = WW'(row_i) * WW'(COLS) + WW'(col_i);
        in_range_o = (col_i < CW'(COLS)) && (wide < WW'(DEPTH));
        lin_o      = in_range_o ? wide[AW-1:0] : '0;
    end

endmodule

// File: rtl/dispram_store.sv
module dispram_store #(
    parameter int unsigned DEPTH = 495,
    parameter int unsigned AW    = 9,
    parameter int unsigned DW    = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] addr_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[addr_i] <= wdata_i;
    end

    always_comb begin
        rdata_o = (addr_i < AW'(DEPTH)) ? mem[addr_i] : '0;
    end

    // R7: out-of-range cells never reach the array
    p_write_in_bounds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |-> (addr_i < AW'(DEPTH)));

endmodule

// File: rtl/dispram_cpu_port.sv
module dispram_cpu_port
    import dispram_pkg::*;
#(
    parameter int unsigned RW = 4,
    parameter int unsigned CW = 6,
    parameter int unsigned DW = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          cpu_slot_i,
    input  logic          valid_i,
    input  sel_e          sel_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          acc_en_o,
    output logic          acc_we_o,
    output logic [RW-1:0] acc_row_o,
    output logic [CW-1:0] acc_col_o,
    output logic [DW-1:0] acc_wdata_o,
    output logic          ack_o,
    output logic [DW-1:0] rdata_o
);
    typedef struct packed {
        logic [RW-1:0] row;
        logic [CW-1:0] col;
        logic          pend_v;
        logic          pend_we;
        logic [RW-1:0] pend_row;
        logic [CW-1:0] pend_col;
        logic [DW-1:0] pend_wdata;
        logic [1:0]    ack_pipe;
        logic [DW-1:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;
    logic        new_acc;

    always_comb begin
        st_d        = st_q;
        new_acc     = valid_i && (sel_i == SEL_DATA);
        acc_en_o    = 1'b0;
        acc_we_o    = 1'b0;
        acc_row_o   = st_q.row;
        acc_col_o   = st_q.col;
        acc_wdata_o = wdata_i;

        if (valid_i && sel_i == SEL_ROW) st_d.row = wdata_i[RW-1:0];
        if (valid_i && sel_i == SEL_COL) st_d.col = wdata_i[CW-1:0];

        if (st_q.pend_v) begin
            acc_en_o    = 1'b1;
            acc_we_o    = st_q.pend_we;
            acc_row_o   = st_q.pend_row;
            acc_col_o   = st_q.pend_col;
            acc_wdata_o = st_q.pend_wdata;
            st_d.pend_v = 1'b0;
        end else if (new_acc && cpu_slot_i) begin
            acc_en_o = 1'b1;
            acc_we_o = we_i;
        end else if (new_acc) begin
            st_d.pend_v     = 1'b1;
            st_d.pend_we    = we_i;
            st_d.pend_row   = st_q.row;
            st_d.pend_col   = st_q.col;
            st_d.pend_wdata = wdata_i;
        end

        if (acc_en_o && !acc_we_o) st_d.rdata = mem_rdata_i;
        st_d.ack_pipe = {st_q.ack_pipe[0], new_acc};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ack_o   = st_q.ack_pipe[1];
    assign rdata_o = st_q.rdata;

    // R4: a parked request is served in the very next slot
    p_pend_served_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pend_v |-> (acc_en_o && cpu_slot_i));
    // R4: completion exactly two cycles after the request
    p_ack_latency_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_acc |-> ##2 ack_o);
    // R4: request spacing rule
    p_req_spacing_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        new_acc |=> !new_acc);

endmodule

// File: rtl/dispram_slot_arbiter.sv
module dispram_slot_arbiter
    import dispram_pkg::*;
#(
    parameter int unsigned ROWS = 15,
    parameter int unsigned COLS = 33,
    parameter int unsigned DW   = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    output logic                       disp_slot_o,
    input  logic [$clog2(ROWS+1)-1:0]  disp_row_i,
    input  logic [$clog2(COLS)-1:0]    disp_col_i,
    output logic [DW-1:0]              disp_data_o,
    input  logic                       cpu_valid_i,
    input  logic [1:0]                 cpu_sel_i,
    input  logic                       cpu_we_i,
    input  logic [DW-1:0]              cpu_wdata_i,
    output logic                       cpu_ack_o,
    output logic [DW-1:0]              cpu_rdata_o
);
    localparam int unsigned RW    = $clog2(ROWS + 1);
    localparam int unsigned CW    = $clog2(COLS);
    localparam int unsigned DEPTH = ROWS * COLS;
    localparam int unsigned AW    = $clog2(DEPTH);

    typedef struct packed {
        logic          phase;
        logic [DW-1:0] disp_data;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [RW-1:0] port_row [NUM_PORTS];
    logic [CW-1:0] port_col [NUM_PORTS];
    logic [AW-1:0] port_lin [NUM_PORTS];
    logic          port_inr [NUM_PORTS];

    logic          cpu_slot;
    logic          acc_en, acc_we;
    logic [RW-1:0] acc_row;
    logic [CW-1:0] acc_col;
    logic [DW-1:0] acc_wdata;
    logic [AW-1:0] ram_addr;
    logic          ram_we;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] cpu_mem_rd;

    assign disp_slot_o = ~st_q.phase;
    assign cpu_slot    = st_q.phase;

    assign port_row[PORT_DISP] = disp_row_i;
    assign port_col[PORT_DISP] = disp_col_i;
    assign port_row[PORT_CPU]  = acc_row;
    assign port_col[PORT_CPU]  = acc_col;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
        dispram_addr_map #(
            .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW), .AW(AW)
        ) map_i (
            .row_i      (port_row[p]),
            .col_i      (port_col[p]),
            .lin_o      (port_lin[p]),
            .in_range_o (port_inr[p])
        );
    end

    dispram_cpu_port #(.RW(RW), .CW(CW), .DW(DW)) cpu_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cpu_slot_i  (cpu_slot),
        .valid_i     (cpu_valid_i),
        .sel_i       (sel_e'(cpu_sel_i)),
        .we_i        (cpu_we_i),
        .wdata_i     (cpu_wdata_i),
        .mem_rdata_i (cpu_mem_rd),
        .acc_en_o    (acc_en),
        .acc_we_o    (acc_we),
        .acc_row_o   (acc_row),
        .acc_col_o   (acc_col),
        .acc_wdata_o (acc_wdata),
        .ack_o       (cpu_ack_o),
        .rdata_o     (cpu_rdata_o)
    );

    dispram_store #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) store_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (ram_addr),
        .we_i    (ram_we),
        .wdata_i (acc_wdata),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        ram_addr   = cpu_slot ? port_lin[PORT_CPU] : port_lin[PORT_DISP];
        ram_we     = cpu_slot && acc_en && acc_we && port_inr[PORT_CPU];
        cpu_mem_rd = port_inr[PORT_CPU] ? ram_rdata : '0;

        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (!cpu_slot) st_d.disp_data = port_inr[PORT_DISP] ? ram_rdata : '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign disp_data_o = st_q.disp_data;

    // R1: processor accesses only in processor slots
    p_cpu_in_own_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_en |-> !disp_slot_o);
    // R2: display result held through the processor slot
    p_disp_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !disp_slot_o |=> $stable(disp_data_o));
    // R8: write followed by display read of the same cell returns new byte
    p_write_then_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(ram_we) && disp_slot_o && port_inr[PORT_DISP]
         && port_lin[PORT_DISP] == $past(ram_addr))
        |=> disp_data_o == $past(acc_wdata, 2));

endmodule

// File: tb/dispram_slot_arbiter_tb.sv
module dispram_slot_arbiter_tb_top;
    import dispram_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       disp_slot;
    logic [3:0] disp_row = '0;
    logic [5:0] disp_col = '0;
    logic [7:0] disp_data;
    logic       cpu_valid = 1'b0;
    logic [1:0] cpu_sel = 2'd3;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_ack;
    logic [7:0] cpu_rdata;

    int n_run = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dispram_slot_arbiter dut_i (
        .clk_i(clk), .rst_ni(rst_n), .disp_slot_o(disp_slot),
        .disp_row_i(disp_row), .disp_col_i(disp_col), .disp_data_o(disp_data),
        .cpu_valid_i(cpu_valid), .cpu_sel_i(cpu_sel), .cpu_we_i(cpu_we),
        .cpu_wdata_i(cpu_wdata), .cpu_ack_o(cpu_ack), .cpu_rdata_o(cpu_rdata)
    );

    // {row, col, byte}
    localparam logic [17:0] VEC [8] = '{
        {4'd0,  6'd0,  8'h11}, {4'd0,  6'd32, 8'h22},
        {4'd1,  6'd0,  8'h33}, {4'd14, 6'd32, 8'hA5},
        {4'd7,  6'd16, 8'h5A}, {4'd3,  6'd1,  8'hFF},
        {4'd14, 6'd0,  8'h00}, {4'd0,  6'd1,  8'h80}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cpu_op(input sel_e sel, input logic we, input logic [7:0] wd,
                          input bit chk_rd, input logic [7:0] exp, input string tag);
        cpu_valid = 1'b1; cpu_sel = sel; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0; cpu_sel = SEL_NONE;
        if (sel == SEL_DATA) begin
            check(cpu_ack == 1'b0, {tag, " R4 ack early"}, 16'(cpu_ack), 16'd0);
            @(negedge clk);
            check(cpu_ack == 1'b1, {tag, " R4 ack at t+2"}, 16'(cpu_ack), 16'd1);
            if (chk_rd) check(cpu_rdata == exp, {tag, " read byte"}, 16'(cpu_rdata), 16'(exp));
        end
    endtask

    task automatic set_pos(input logic [3:0] r, input logic [5:0] c);
        cpu_op(SEL_ROW, 1'b0, 8'(r), 1'b0, 8'h0, "R3");
        cpu_op(SEL_COL, 1'b0, 8'(c), 1'b0, 8'h0, "R3");
    endtask

    task automatic wait_disp();
        while (!disp_slot) @(negedge clk);
    endtask

    task automatic wait_cpu();
        while (disp_slot) @(negedge clk);
    endtask

    task automatic disp_read(input logic [3:0] r, input logic [5:0] c,
                             input logic [7:0] exp, input string tag);
        wait_disp();
        disp_row = r; disp_col = c;
        @(negedge clk);
        check(disp_data == exp, {tag, " R2 display byte"}, 16'(disp_data), 16'(exp));
        @(negedge clk);
        check(disp_data == exp, {tag, " R2 display hold"}, 16'(disp_data), 16'(exp));
    endtask

    always @(negedge clk) begin
        if (mon_en)
            check(disp_data == 8'hA5, "R5 display undisturbed", 16'(disp_data), 16'hA5);
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check(disp_data == 8'h0, "R9 disp_data reset", 16'(disp_data), 16'h0);
        check(cpu_rdata == 8'h0, "R9 cpu_rdata reset", 16'(cpu_rdata), 16'h0);
        check(cpu_ack == 1'b0, "R9 cpu_ack reset", 16'(cpu_ack), 16'h0);
        rst_n = 1'b1;
        #1;
        // R1 slot order
        check(disp_slot == 1'b1, "R1 first slot display", 16'(disp_slot), 16'h1);
        @(negedge clk);
        check(disp_slot == 1'b0, "R1 second slot cpu", 16'(disp_slot), 16'h0);
        @(negedge clk);
        check(disp_slot == 1'b1, "R1 third slot display", 16'(disp_slot), 16'h1);

        // R9 registers reset to (0,0): write before any load
        cpu_op(SEL_DATA, 1'b1, 8'h6B, 1'b0, 8'h0, "R9");
        disp_read(4'd0, 6'd0, 8'h6B, "R9 write at (0,0)");

        // table walk: write all, then read back both sides (R3, R6)
        for (int i = 0; i < 8; i++) begin
            set_pos(VEC[i][17:14], VEC[i][13:8]);
            cpu_op(SEL_DATA, 1'b1, VEC[i][7:0], 1'b0, 8'h0, "R3 write");
        end
        for (int i = 0; i < 8; i++) begin
            set_pos(VEC[i][17:14], VEC[i][13:8]);
            cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, VEC[i][7:0], "R6 cpu readback");
            disp_read(VEC[i][17:14], VEC[i][13:8], VEC[i][7:0], "R6 disp readback");
        end

        // R4 request placed in a display slot, then in a processor slot
        set_pos(4'd7, 6'd16);
        wait_disp();
        cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, 8'h5A, "R4 in display slot");
        wait_cpu();
        cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, 8'h5A, "R4 in cpu slot");

        // R7 out of range
        set_pos(4'd0, 6'd33);
        cpu_op(SEL_DATA, 1'b1, 8'hEE, 1'b0, 8'h0, "R7");
        cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, 8'h00, "R7 read (0,33)");
        set_pos(4'd1, 6'd0);
        cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, 8'h33, "R7 (1,0) untouched");
        set_pos(4'd15, 6'd0);
        cpu_op(SEL_DATA, 1'b1, 8'hEE, 1'b0, 8'h0, "R7");
        cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, 8'h00, "R7 read (15,0)");
        disp_read(4'd15, 6'd5, 8'h00, "R7 disp row 15");
        disp_read(4'd0, 6'd40, 8'h00, "R7 disp col 40");

        // R5 display holds (14,32) during processor writes elsewhere
        wait_disp();
        disp_row = 4'd14; disp_col = 6'd32;
        @(negedge clk); @(negedge clk);
        mon_en = 1'b1;
        set_pos(4'd2, 6'd2);
        cpu_op(SEL_DATA, 1'b1, 8'h01, 1'b0, 8'h0, "R5");
        set_pos(4'd14, 6'd31);
        cpu_op(SEL_DATA, 1'b1, 8'h02, 1'b0, 8'h0, "R5");
        wait_disp();
        cpu_op(SEL_DATA, 1'b1, 8'h03, 1'b0, 8'h0, "R5");
        mon_en = 1'b0;

        // R8 write in processor slot, display read next slot
        set_pos(4'd3, 6'd9);
        cpu_op(SEL_DATA, 1'b1, 8'h11, 1'b0, 8'h0, "R8 seed");
        disp_read(4'd3, 6'd9, 8'h11, "R8 seed");
        wait_cpu();
        cpu_valid = 1'b1; cpu_sel = SEL_DATA; cpu_we = 1'b1; cpu_wdata = 8'h3C;
        disp_row = 4'd3; disp_col = 6'd9;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0; cpu_sel = SEL_NONE;
        @(negedge clk);
        check(disp_data == 8'h3C, "R8 fresh byte on display", 16'(disp_data), 16'h3C);
        check(cpu_ack == 1'b1, "R4 ack on R8 write", 16'(cpu_ack), 16'h1);

        // R3 selector 3 does nothing
        cpu_op(SEL_NONE, 1'b1, 8'h99, 1'b0, 8'h0, "R3");
        cpu_op(SEL_DATA, 1'b0, 8'h0, 1'b1, 8'h3C, "R3 sel none no effect");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule